// File: doc/BRIEF.md
# Sparse Row Multiply-Accumulate Engine

This engine forms the weighted sum of one neuron from a pruned weight row. Only the nonzero weights reach it. Each one arrives with the number of zero weights that were skipped in front of it. A 64-bit stream word carries three such pairs. From each pair the engine rebuilds the absolute position of the weight in the row. It fetches the matching input activation through one of three parallel read ports, multiplies the two and adds the product into a 32-bit accumulator.

The row length is not sent with the data. It comes from a configuration input that gives the number of input activations in the layer. A row ends at the first pair whose rebuilt position lands at or past that count. That pair is a padding marker and adds nothing. The engine then emits the finished sum for one cycle, clears its position offset and treats the next word as the start of a new row.

`cfg_len` must stay constant while any word of a row is inside the pipeline.

Top module: `sparse_row_mac`

## Requirements
- R1: Word layout. Pair i (i = 0, 1, 2) occupies bits [21i+20:21i]. Its signed Q7.8 weight is in bits [21i+20:21i+5] and its unsigned 5-bit skip count is in bits [21i+4:21i]. Bit 63 has no effect on any output.
- R2: Each word has a running row offset `base`. The position of pair i in that word is base + i + (the sum of the skip counts of pairs 0 through i). This position is driven on read port i, on bits [10i+9:10i] of `mem_addr`.
- R3: All three read addresses are presented in the same cycle. The activation for port i is taken from bits [16i+15:16i] of `mem_rdata` one clock after its address is presented, as from a synchronous-read memory.
- R4: Each product is a signed 16x16 multiply. Products are summed in a 32-bit two's-complement accumulator that wraps on overflow, and `res_sum` carries that value.
- R5: A pair whose position is at or past `cfg_len` ends the row and adds nothing. Later pairs in the same word are discarded. The next accepted word starts a new row with `base` = 0.
- R6: After a word that does not end the row, `base` for the next word is its old value plus 3 plus the sum of that word's three skip counts. A row may fill every position up to `cfg_len`-1 and end on the first pair of the following word.
- R7: A row whose first pair is already out of range produces exactly one result with sum 0. With `cfg_len` = 0, every word is such a row.
- R8: Exactly one `res_valid` pulse of one cycle is produced per row, and results come out in row order. If the ending word is accepted at clock edge E, `res_valid` is high for the cycle that follows edge E+3.
- R9: While `rst_n` is low (synchronous, active low), `res_valid` and `in_ready` are 0. After reset `in_ready` is 1 and a word is taken on every edge where `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_len | input | 10 | Number of input activations in the layer |
| in_valid | input | 1 | Stream word valid |
| in_ready | output | 1 | Stream word accepted when high together with in_valid |
| in_word | input | 64 | Three packed weight/skip-count pairs |
| mem_addr | output | 30 | Three activation read addresses, port i at [10i+9:10i] |
| mem_rdata | input | 48 | Three activations, one clock after their addresses, port i at [16i+15:16i] |
| res_valid | output | 1 | One-cycle strobe for a finished row |
| res_sum | output | 32 | Weighted sum of the finished row |

## Verification
The corner cases targeted are these:
- A row that ends on pair 1 or pair 2 of a word. If the discarded pairs were summed, the result would be off by the junk products placed there.
- A row that fills its last position exactly and ends on the first pair of the next word. An off-by-one in the range compare would add one extra product or drop the last real one.
- A row whose first pair is already out of range, with `cfg_len` of 0, 20 and 31. A design that needed at least one product before closing a row would hang or merge two rows.
- Back-to-back rows. A stale offset would shift every address of the second row.
- Maximum skip counts of 31 and a maximum layer length of 1023, which expose adder width and truncation faults.
- Junk in bit 63.

// File: rtl/sprow_pkg.sv
// Shared definitions for the sparse row multiply-accumulate engine.
// Assumes: a single clock domain; every stage carries the same control bundle.
package sprow_pkg;
    localparam int DEF_TUPLES  = 3;   // weight/skip pairs per stream word
    localparam int DEF_WGT_W   = 16;  // Q7.8 weight and activation width
    localparam int DEF_SKIP_W  = 5;   // zero-run length field width
    localparam int DEF_ADDR_W  = 10;  // activation memory address width
    localparam int DEF_ACC_W   = 32;  // accumulator width
    localparam int DEF_WORD_W  = 64;  // stream word width

    // Control bundle that travels beside the data through each pipeline stage.
    typedef struct packed {
        logic vld;    // stage holds a word
        logic last;   // this word closed its row
    } stage_ctl_t;
endpackage

// File: rtl/sprow_addr_gen.sv
// Address stage: splits a stream word into pairs and rebuilds each pair's
// absolute row position from the running offset plus the skip counts seen so
// far (one multi-input sum per pair). It flags the pairs that lie inside the
// layer, detects the end of the row and keeps the row offset.
// Assumes: cfg_len is stable while a row is in flight; take is a handshake.
module sprow_addr_gen
    import sprow_pkg::*;
#(
    parameter int N_TUP  = DEF_TUPLES,
    parameter int W_W    = DEF_WGT_W,
    parameter int Z_W    = DEF_SKIP_W,
    parameter int A_W    = DEF_ADDR_W,
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [A_W-1:0]                cfg_len,
    input  logic                          take,
    input  logic [WORD_W-1:0]             word,
    output stage_ctl_t                    ctl_q,
    output logic [N_TUP-1:0]              mask_q,
    output logic [N_TUP-1:0][A_W-1:0]     addr_q,
    output logic [N_TUP-1:0][W_W-1:0]     wgt_q
);
    localparam int TUP_W = W_W + Z_W;
    localparam int OFS_W = A_W + 1;
    localparam int SUM_W = A_W + Z_W + $clog2(N_TUP + 1) + 1;

    logic [OFS_W-1:0]            base_q;
    logic [OFS_W-1:0]            base_nxt;
    logic [N_TUP-1:0][Z_W-1:0]   skip;
    logic [N_TUP-1:0][W_W-1:0]   wgt;
    logic [N_TUP-1:0][SUM_W-1:0] pos;
    logic [N_TUP-1:0]            in_rng;
    logic [N_TUP-1:0]            mask_c;
    logic                        row_end;

    // Field extraction for every pair of the word.
    for (genvar g = 0; g < N_TUP; g++) begin : g_split
        assign skip[g] = word[g*TUP_W +: Z_W];
        assign wgt[g]  = word[g*TUP_W + Z_W +: W_W];
    end

    // Spare word bits beyond the last pair carry no meaning.
    if (WORD_W > N_TUP*TUP_W) begin : g_spare
        logic unused_spare;
        assign unused_spare = ^word[WORD_W-1:N_TUP*TUP_W];
    end

    // Position of each pair: offset + index + skip counts up to and including it.
    always_comb begin
        logic [SUM_W-1:0] s;
        for (int i = 0; i < N_TUP; i++) begin
            s = SUM_W'(base_q) + SUM_W'(i);
            for (int k = 0; k <= i; k++) begin
                s = s + SUM_W'(skip[k]);
            end
            pos[i]    = s;
            in_rng[i] = s < SUM_W'(cfg_len);
        end
    end

    // A pair counts only if it and every pair before it lie inside the layer.
    always_comb begin
        logic live;
        live = 1'b1;
        for (int i = 0; i < N_TUP; i++) begin
            live      = live & in_rng[i];
            mask_c[i] = live;
        end
        row_end  = ~live;
        base_nxt = row_end ? '0 : OFS_W'(pos[N_TUP-1] + SUM_W'(1));
    end

    // Stage register and row offset update on every accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            ctl_q  <= '0;
            mask_q <= '0;
            addr_q <= '0;
            wgt_q  <= '0;
        end else begin
            ctl_q.vld <= take;
            if (take) begin
                base_q     <= base_nxt;
                ctl_q.last <= row_end;
                mask_q     <= mask_c;
                wgt_q      <= wgt;
                for (int i = 0; i < N_TUP; i++) begin
                    addr_q[i] <= A_W'(pos[i]);
                end
            end else begin
                ctl_q.last <= 1'b0;
                mask_q     <= '0;
            end
        end
    end

    // Counted pairs must form a prefix: 000, 001, 011, 111.
    assert_mask_prefix_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.vld |-> $onehot0({1'b0, mask_q} + (N_TUP+1)'(1)));

    // The offset never passes the layer length while the length is held.
    assert_base_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cfg_len) |-> (base_q <= OFS_W'(cfg_len)));

    for (genvar g = 0; g < N_TUP; g++) begin : g_chk
        // Every counted pair reads inside the layer.
        assert_addr_in_layer_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_q.vld && mask_q[g]) |-> (addr_q[g] < cfg_len));
        if (g > 0) begin : g_mono
            // Positions rise strictly across the pairs of one word.
            assert_addr_rising_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (ctl_q.vld && mask_q[g]) |-> (addr_q[g] > addr_q[g-1]));
        end
    end
endmodule

// File: rtl/sprow_mul_stage.sv
// Multiply stage: holds the weights for one cycle while the activation memory
// answers, then forms one signed product per pair. Pairs outside the row give 0.
// Assumes: the read data arrives exactly one clock after the address.
module sprow_mul_stage
    import sprow_pkg::*;
#(
    parameter int N_TUP = DEF_TUPLES,
    parameter int W_W   = DEF_WGT_W,
    parameter int ACC_W = DEF_ACC_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  stage_ctl_t                    ctl_in,
    input  logic [N_TUP-1:0]              mask_in,
    input  logic [N_TUP-1:0][W_W-1:0]     wgt_in,
    input  logic [N_TUP-1:0][W_W-1:0]     rdata,
    output stage_ctl_t                    ctl_q,
    output logic [N_TUP-1:0][ACC_W-1:0]   prod_q
);
    localparam int PROD_W = 2 * W_W;

    stage_ctl_t                  s2_ctl;
    logic [N_TUP-1:0]            s2_mask;
    logic [N_TUP-1:0][W_W-1:0]   s2_wgt;
    logic [N_TUP-1:0][ACC_W-1:0] prod_c;

    // One signed multiplier per pair, widened to the accumulator width.
    for (genvar g = 0; g < N_TUP; g++) begin : g_mul
        logic signed [PROD_W-1:0] p;
        logic signed [ACC_W-1:0]  pe;
        assign p         = $signed(s2_wgt[g]) * $signed(rdata[g]);
        assign pe        = ACC_W'(p);
        assign prod_c[g] = s2_mask[g] ? pe : '0;
    end

    // Align the weights with the memory latency, then register the products.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_ctl  <= '0;
            s2_mask <= '0;
            s2_wgt  <= '0;
            ctl_q   <= '0;
            prod_q  <= '0;
        end else begin
            s2_ctl  <= ctl_in;
            s2_mask <= mask_in;
            s2_wgt  <= wgt_in;
            ctl_q   <= s2_ctl;
            prod_q  <= prod_c;
        end
    end

    // Products only move with a word behind them.
    assert_prod_follows_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q.vld |-> (prod_q == '0));
endmodule

// File: rtl/sprow_accum.sv
// Accumulate stage: adds the products of each word into the running row sum.
// On the word that closes a row it presents the total for one cycle and
// clears the sum for the next row.
// Assumes: products are already zero for pairs outside the row.
module sprow_accum
    import sprow_pkg::*;
#(
    parameter int N_TUP = DEF_TUPLES,
    parameter int ACC_W = DEF_ACC_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  stage_ctl_t                    ctl_in,
    input  logic [N_TUP-1:0][ACC_W-1:0]   prod_in,
    output logic                          res_valid,
    output logic [ACC_W-1:0]              res_sum
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] total;

    // Running sum plus all products of the current word (wraps at ACC_W bits).
    always_comb begin
        total = acc_q;
        for (int i = 0; i < N_TUP; i++) begin
            total = total + prod_in[i];
        end
    end

    // Hold the partial sum, or hand it out and clear it at the row end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q     <= '0;
            res_valid <= 1'b0;
            res_sum   <= '0;
        end else begin
            res_valid <= 1'b0;
            if (ctl_in.vld) begin
                if (ctl_in.last) begin
                    res_sum   <= total;
                    res_valid <= 1'b1;
                    acc_q     <= '0;
                end else begin
                    acc_q <= total;
                end
            end
        end
    end

    // A result strobe is always caused by a row-closing word one stage earlier.
    assert_result_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $past(ctl_in.vld && ctl_in.last));
endmodule

// File: rtl/sparse_row_mac.sv
// Top of the sparse row multiply-accumulate engine.
// Pipeline: address -> activation read -> multiply -> accumulate.
// Assumes: the activation memory has one synchronous read port per pair and
// answers one clock after the address; cfg_len is held while a row is in flight.
module sparse_row_mac
    import sprow_pkg::*;
#(
    parameter int N_TUP  = DEF_TUPLES,
    parameter int W_W    = DEF_WGT_W,
    parameter int Z_W    = DEF_SKIP_W,
    parameter int A_W    = DEF_ADDR_W,
    parameter int ACC_W  = DEF_ACC_W,
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [A_W-1:0]         cfg_len,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [WORD_W-1:0]      in_word,
    output logic [N_TUP*A_W-1:0]   mem_addr,
    input  logic [N_TUP*W_W-1:0]   mem_rdata,
    output logic                   res_valid,
    output logic [ACC_W-1:0]       res_sum
);
    stage_ctl_t                  s1_ctl;
    stage_ctl_t                  s3_ctl;
    logic [N_TUP-1:0]            s1_mask;
    logic [N_TUP-1:0][A_W-1:0]   s1_addr;
    logic [N_TUP-1:0][W_W-1:0]   s1_wgt;
    logic [N_TUP-1:0][W_W-1:0]   rdata;
    logic [N_TUP-1:0][ACC_W-1:0] s3_prod;
    logic                        take;

    // The pipeline never stalls, so ready only waits for reset to end.
    always_ff @(posedge clk) begin
        if (!rst_n) in_ready <= 1'b0;
        else        in_ready <= 1'b1;
    end

    assign take = in_valid & in_ready;

    // Flat port packing for the replicated read ports.
    for (genvar g = 0; g < N_TUP; g++) begin : g_port
        assign mem_addr[g*A_W +: A_W] = s1_addr[g];
        assign rdata[g]               = mem_rdata[g*W_W +: W_W];
    end

    sprow_addr_gen #(
        .N_TUP(N_TUP), .W_W(W_W), .Z_W(Z_W), .A_W(A_W), .WORD_W(WORD_W)
    ) u_addr (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .take(take), .word(in_word),
        .ctl_q(s1_ctl), .mask_q(s1_mask), .addr_q(s1_addr), .wgt_q(s1_wgt)
    );

    sprow_mul_stage #(
        .N_TUP(N_TUP), .W_W(W_W), .ACC_W(ACC_W)
    ) u_mul (
        .clk(clk), .rst_n(rst_n), .ctl_in(s1_ctl), .mask_in(s1_mask),
        .wgt_in(s1_wgt), .rdata(rdata), .ctl_q(s3_ctl), .prod_q(s3_prod)
    );

    sprow_accum #(
        .N_TUP(N_TUP), .ACC_W(ACC_W)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .ctl_in(s3_ctl), .prod_in(s3_prod),
        .res_valid(res_valid), .res_sum(res_sum)
    );

    // No result strobe in the first cycle after reset.
    assert_quiet_after_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !res_valid);

    // Ready stays high once reset has been released.
    assert_ready_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> in_ready);
endmodule

// File: tb/sparse_row_mac_bench.sv
`timescale 1ns/1ps
module sparse_row_mac_bench;
    localparam int N = 3, WW = 16, ZW = 5, AW = 10, WORDW = 64, ACCW = 32, TW = WW + ZW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [AW-1:0]    cfg_len;
    logic             in_valid;
    logic             in_ready;
    logic [WORDW-1:0] in_word;
    logic [N*AW-1:0]  mem_addr;
    logic [N*WW-1:0]  mem_rdata;
    logic             res_valid;
    logic [ACCW-1:0]  res_sum;

    sparse_row_mac u_sparse_row_mac (
        .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .in_valid(in_valid),
        .in_ready(in_ready), .in_word(in_word), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .res_valid(res_valid), .res_sum(res_sum)
    );

    // Replicated activation memory with synchronous read (R3).
    logic [WW-1:0] mem [0:(1<<AW)-1];
    always @(posedge clk) begin
        for (int i = 0; i < N; i++) mem_rdata[i*WW +: WW] <= mem[mem_addr[i*AW +: AW]];
    end

    int  checks = 0, errors = 0, cyc = 0, rows_sent = 0, rows_seen = 0;
    bit  done = 1'b0;
    int  exp_q[$];
    int  cyc_q[$];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Result monitor: value (R4) and timing (R8) against the queued reference.
    always @(negedge clk) begin
        int e, c;
        if (rst_n && res_valid && !done) begin
            rows_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected result", longint'($signed(res_sum)), 0);
            end else begin
                e = exp_q.pop_front();
                c = cyc_q.pop_front();
                check($signed(res_sum) == e, "R4 R5 row sum", longint'($signed(res_sum)), e);
                check(cyc == c, "R8 result cycle", cyc, c);
            end
        end
    end

    task automatic drive_word(input logic [WORDW-1:0] w, input bit ends, input int expv);
        int gap;
        gap = ($urandom % 3 == 0) ? int'($urandom % 3) : 0;
        repeat (gap) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        if (ends) begin
            exp_q.push_back(expv);
            cyc_q.push_back(cyc + 4);  // accepted at the next edge, visible after three more
            rows_sent++;
        end
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    // Reference: walk the pairs with a running position, per R1, R2, R5, R6.
    task automatic send_row(input logic [WW-1:0] ws[$], input int zs[$]);
        int pos = 0, expv = 0, slot = 0, a;
        logic [WORDW-1:0] w;
        w = {$urandom, $urandom};  // junk in bit 63 and in discarded slots (R1, R5)
        for (int t = 0; t < ws.size(); t++) begin
            w[slot*TW +: ZW]      = ZW'(zs[t]);
            w[slot*TW + ZW +: WW] = ws[t];
            a = pos + zs[t];
            if (a >= int'(cfg_len)) begin
                drive_word(w, 1'b1, expv);
                return;
            end
            expv += $signed(ws[t]) * $signed(mem[a]);
            pos = a + 1;
            slot++;
            if (slot == N) begin
                drive_word(w, 1'b0, 0);
                w = {$urandom, $urandom};
                slot = 0;
            end
        end
        $display("bench error: row list without end marker");
    endtask

    task automatic rand_row();
        logic [WW-1:0] ws[$];
        int zs[$];
        int pos = 0, z;
        forever begin
            z = ($urandom % 5 == 0) ? int'($urandom % 32) : int'($urandom % 3);
            ws.push_back(($urandom % 8 == 0) ? 16'h0000 : WW'($urandom));
            zs.push_back(z);
            if (pos + z >= int'(cfg_len)) break;
            pos = pos + z + 1;
        end
        send_row(ws, zs);
    endtask

    task automatic drain();
        repeat (8) @(negedge clk);
    endtask

    initial begin
        logic [WW-1:0] ws[$];
        int zs[$];
        int lens[6];
        void'($urandom(32'd20240611));
        for (int i = 0; i < (1<<AW); i++) mem[i] = WW'($urandom);
        in_valid = 1'b0;
        in_word  = '0;
        cfg_len  = '0;
        repeat (4) @(negedge clk);
        check(res_valid == 1'b0, "R9 res_valid in reset", res_valid, 0);
        check(in_ready == 1'b0, "R9 in_ready in reset", in_ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R9 in_ready after reset", in_ready, 1);
        check(res_valid == 1'b0, "R9 res_valid after reset", res_valid, 0);

        // Worked row: signed Q7.8 weights at positions 1,4,5,9,12,14 (R1, R2, R6).
        cfg_len = 10'd16;
        ws = '{16'hFE80, 16'h004D, 16'hFFD4, 16'h011A, 16'hFFCD, 16'h001A, 16'h7FFF};
        zs = '{1, 2, 0, 3, 2, 1, 1};
        send_row(ws, zs);
        drain();

        // Row ends on pair 1; next word must restart at offset 0 (R5).
        cfg_len = 10'd10;
        ws = '{16'h0100, 16'h7FFF};       zs = '{2, 20};  send_row(ws, zs);
        ws = '{16'h0200, 16'h0001};       zs = '{0, 31};  send_row(ws, zs);
        ws = '{16'h8000, 16'h7FFF, 16'h1234}; zs = '{4, 1, 31}; send_row(ws, zs);
        drain();

        // Exact fill: positions 0..5, closed by pair 0 of the next word (R6).
        cfg_len = 10'd6;
        ws = '{16'h0101, 16'hFF00, 16'h7FFF, 16'h8000, 16'h0003, 16'h00FF, 16'h5555};
        zs = '{0, 0, 0, 0, 0, 0, 0};
        send_row(ws, zs);
        drain();

        // Empty rows (R7).
        cfg_len = 10'd20;
        ws = '{16'h7FFF}; zs = '{25}; send_row(ws, zs);
        cfg_len = 10'd31;
        ws = '{16'h4000}; zs = '{31}; send_row(ws, zs);
        drain();
        cfg_len = 10'd0;
        ws = '{16'h1111}; zs = '{0}; send_row(ws, zs);
        ws = '{16'h2222}; zs = '{7}; send_row(ws, zs);
        drain();

        // Random rows across layer lengths, incl. maximum 1023 (R2, R4, R6).
        lens = '{1, 7, 32, 100, 257, 1023};
        for (int ph = 0; ph < 6; ph++) begin
            cfg_len = AW'(lens[ph]);
            for (int r = 0; r < ((lens[ph] > 300) ? 12 : 40); r++) rand_row();
            drain();
        end

        drain();
        check(rows_seen == rows_sent, "R8 one result per row", rows_seen, rows_sent);
        check(exp_q.size() == 0, "R8 no missing results", exp_q.size(), 0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "R8 watchdog expired", cyc, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule